// File: doc/BRIEF.md
# Transmit Buffer Priority Arbitrator

This block chooses which of several transmit buffers supplies the next frame to a CAN-style protocol engine. Among the buffers that report themselves ready, the one with the largest priority value wins. The block then reads that frame's four metadata words out of the winning buffer's RAM. Each buffer's RAM is synchronous and returns data one clock after it sees an address. The block drives a single shared word address, and a registered buffer index selects which RAM's read data is used.

The word address always comes straight from a register. It never comes from the priority decode. The decoder's result only steers the controller's next-state logic, so the path from the priority inputs ends at flip-flops and does not reach the RAM address pins. The cost is one extra cycle at the start of each load.

Software and hardware command strobes can arrive in any cycle, including the same one. A hardware strobe (frame sent or arbitration lost) returns the block to idle. A software strobe makes it reload the metadata of whichever buffer is currently selected.

Top module: `tx_prio_arbiter`

## Requirements
- R1: During and after a synchronous active-high reset, the block is idle, `frame_ready` is 0 and `ram_addr` is 0.
- R2: The decoder considers only buffers whose `buf_ready` bit is 1 and selects the one with the largest 3-bit priority, where buffer i's priority is `buf_prio[3*i+2:3*i]`. `sel_valid` is 1 exactly when at least one buffer is ready. `sel_idx` is 0 when no buffer is ready.
- R3: Among ready buffers that share the top priority, the lowest index wins.
- R4: A load starts at a clock edge where the block is idle, `sel_valid` is 1 and `hw_cmd` is 0. `ram_addr` is 0 after that edge, then steps to 1, 2 and 3 on the next three edges, and then holds at 3.
- R5: `fmt_word` captures word 0 and `id_word` captures word 1. `ts_word` captures word 3 in its upper half and word 2 in its lower half. `frame_ready` rises at the fifth edge after the load start, and `frm_buf` then names the buffer that was read.
- R6: If `sel_idx` differs from the buffer being loaded or held, the next edge restarts the load from word 0 on the new buffer and clears `frame_ready`.
- R7: A `sw_cmd` pulse while loading or holding a frame, with `hw_cmd` low, restarts the load from word 0 of the selected buffer and clears `frame_ready`.
- R8: A `hw_cmd` pulse returns the block to idle and clears `frame_ready`, and it takes precedence over a simultaneous `sw_cmd`. A new load starts at the following edge if a buffer is ready.
- R9: With no ready buffer, the block stays idle and `frame_ready` stays 0. If every buffer drops out of ready during a load, the block returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| buf_ready | input | NBUF | Per-buffer ready flags |
| buf_prio | input | NBUF*PW | Per-buffer priority fields, buffer i at bits [PW*i +: PW] |
| sw_cmd | input | 1 | Software command strobe: reload metadata |
| hw_cmd | input | 1 | Hardware strobe: frame sent or arbitration lost |
| ram_rdata | input | NBUF*DW | Read data of every buffer RAM, buffer i at [DW*i +: DW] |
| ram_addr | output | 2 | Registered word address shared by all buffer RAMs |
| sel_idx | output | IW | Index chosen by the priority decoder |
| sel_valid | output | 1 | At least one buffer is ready |
| frm_buf | output | IW | Buffer whose metadata is being loaded or held |
| fmt_word | output | DW | Frame-format word |
| id_word | output | DW | Identifier word |
| ts_word | output | 2*DW | Timestamp, high word above low word |
| frame_ready | output | 1 | All four words captured |

## Verification
A stale buffer lock or a wrong load counter shows up at the ports within a few edges. `ram_addr` would fail to return to 0 one edge after a restart, or `frame_ready` would rise an edge early or late. The captured words would carry another buffer's tag, because every RAM word in the bench encodes its buffer and word number. A wrong precedence between the two strobes shows as `frame_ready` returning one edge too soon after a combined pulse.

// File: rtl/tx_prio_arbiter.sv
module tx_prio_arbiter #(
  parameter int NBUF = 4,
  parameter int PW   = 3,
  parameter int DW   = 32,
  localparam int IW  = (NBUF > 1) ? $clog2(NBUF) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NBUF-1:0]   buf_ready,
  input  logic [NBUF*PW-1:0] buf_prio,
  input  logic              sw_cmd,
  input  logic              hw_cmd,
  input  logic [NBUF*DW-1:0] ram_rdata,
  output logic [1:0]        ram_addr,
  output logic [IW-1:0]     sel_idx,
  output logic              sel_valid,
  output logic [IW-1:0]     frm_buf,
  output logic [DW-1:0]     fmt_word,
  output logic [DW-1:0]     id_word,
  output logic [2*DW-1:0]   ts_word,
  output logic              frame_ready
);

  typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_HOLD} state_t;

  state_t        state_q;
  logic [2:0]    fc_q;
  logic [IW-1:0] lock_q;
  logic [1:0]    addr_q;
  logic [PW-1:0] best;
  logic [DW-1:0] cur;

  always_comb begin
    sel_idx   = '0;
    sel_valid = 1'b0;
    best      = '0;
    for (int i = 0; i < NBUF; i++) begin
      if (buf_ready[i] && (!sel_valid || buf_prio[i*PW +: PW] > best)) begin
        sel_valid = 1'b1;
        best      = buf_prio[i*PW +: PW];
        sel_idx   = IW'(i);
      end
    end
  end

  assign cur      = ram_rdata[lock_q*DW +: DW];
  assign ram_addr = addr_q;
  assign frm_buf  = lock_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      fc_q        <= '0;
      lock_q      <= '0;
      addr_q      <= '0;
      frame_ready <= 1'b0;
      fmt_word    <= '0;
      id_word     <= '0;
      ts_word     <= '0;
    end else if (hw_cmd) begin
      state_q     <= ST_IDLE;
      frame_ready <= 1'b0;
    end else if (state_q == ST_IDLE) begin
      if (sel_valid) begin
        state_q <= ST_FETCH;
        lock_q  <= sel_idx;
        addr_q  <= '0;
        fc_q    <= '0;
      end
    end else if (!sel_valid) begin
      state_q     <= ST_IDLE;
      frame_ready <= 1'b0;
    end else if (sw_cmd || sel_idx != lock_q) begin
      state_q     <= ST_FETCH;
      lock_q      <= sel_idx;
      addr_q      <= '0;
      fc_q        <= '0;
      frame_ready <= 1'b0;
    end else if (state_q == ST_FETCH) begin
      fc_q   <= fc_q + 3'd1;
      addr_q <= (fc_q >= 3'd2) ? 2'd3 : fc_q[1:0] + 2'd1;
      case (fc_q)
        3'd1: fmt_word <= cur;
        3'd2: id_word  <= cur;
        3'd3: ts_word[DW-1:0] <= cur;
        3'd4: begin
          ts_word[2*DW-1:DW] <= cur;
          state_q            <= ST_HOLD;
          frame_ready        <= 1'b1;
        end
        default: ;
      endcase
    end
  end

  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (ram_addr == 2'd0 && !frame_ready));

  assert_sel_is_ready_R2: assert property (@(posedge clk) disable iff (rst)
    sel_valid |-> buf_ready[sel_idx]);

  assert_last_word_before_ready_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(frame_ready) |-> $past(ram_addr) == 2'd3);

  assert_ready_names_winner_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(frame_ready) |-> frm_buf == $past(sel_idx));

  assert_sw_restart_R7: assert property (@(posedge clk) disable iff (rst)
    (sw_cmd && !hw_cmd && sel_valid && state_q != ST_IDLE) |=> (ram_addr == 2'd0 && !frame_ready));

  assert_hw_clears_R8: assert property (@(posedge clk) disable iff (rst)
    hw_cmd |=> !frame_ready);

  assert_none_ready_drops_R9: assert property (@(posedge clk) disable iff (rst)
    (frame_ready && !sel_valid && !hw_cmd) |=> !frame_ready);

endmodule

// File: tb/tb_tx_prio_arbiter.sv
`timescale 1ns/1ps
module tb_tx_prio_arbiter;
  localparam int NBUF = 4;
  localparam int PW   = 3;
  localparam int DW   = 32;
  localparam int IW   = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NBUF-1:0] buf_ready = '0;
  logic [NBUF*PW-1:0] buf_prio = '0;
  logic sw_cmd = 1'b0;
  logic hw_cmd = 1'b0;
  logic [NBUF*DW-1:0] ram_rdata;
  logic [1:0] ram_addr;
  logic [IW-1:0] sel_idx, frm_buf;
  logic sel_valid, frame_ready;
  logic [DW-1:0] fmt_word, id_word;
  logic [2*DW-1:0] ts_word;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  tx_prio_arbiter #(.NBUF(NBUF), .PW(PW), .DW(DW)) dut (
    .clk(clk), .rst(rst), .buf_ready(buf_ready), .buf_prio(buf_prio),
    .sw_cmd(sw_cmd), .hw_cmd(hw_cmd), .ram_rdata(ram_rdata),
    .ram_addr(ram_addr), .sel_idx(sel_idx), .sel_valid(sel_valid),
    .frm_buf(frm_buf), .fmt_word(fmt_word), .id_word(id_word),
    .ts_word(ts_word), .frame_ready(frame_ready));

  function automatic logic [DW-1:0] mem_word(int b, int w);
    return 32'hC0DE0000 | DW'(b << 8) | DW'(8'h10 + w);
  endfunction

  always_ff @(posedge clk)
    for (int b = 0; b < NBUF; b++)
      ram_rdata[b*DW +: DW] <= mem_word(b, int'(ram_addr));

  task automatic chk(string rq, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", rq, act, exp);
    end
  endtask

  task automatic expect_load(int b, string rq);
    for (int k = 0; k < 5; k++) begin
      chk(rq, 64'(ram_addr), 64'((k > 3) ? 3 : k));
      chk(rq, 64'(frame_ready), 64'd0);
      @(negedge clk);
    end
    chk(rq, 64'(frame_ready), 64'd1);
    chk(rq, 64'(frm_buf), 64'(b));
    chk("R5", 64'(fmt_word), 64'(mem_word(b, 0)));
    chk("R5", 64'(id_word), 64'(mem_word(b, 1)));
    chk("R5", ts_word, {mem_word(b, 3), mem_word(b, 2)});
  endtask

  localparam logic [18:0] VEC [7] = '{
    {4'b0001, 3'd0, 3'd0, 3'd0, 3'd0, 2'd0, 1'b1},
    {4'b1111, 3'd2, 3'd3, 3'd5, 3'd1, 2'd1, 1'b1},
    {4'b1101, 3'd2, 3'd3, 3'd5, 3'd1, 2'd2, 1'b1},
    {4'b1111, 3'd4, 3'd4, 3'd4, 3'd4, 2'd0, 1'b1},
    {4'b1100, 3'd6, 3'd6, 3'd7, 3'd1, 2'd2, 1'b1},
    {4'b1010, 3'd7, 3'd5, 3'd0, 3'd6, 2'd3, 1'b1},
    {4'b0000, 3'd7, 3'd7, 3'd7, 3'd7, 2'd0, 1'b0}
  };

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog actual hung expected finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", 64'(frame_ready), 64'd0);
    chk("R1", 64'(ram_addr), 64'd0);
    rst = 1'b0;

    // R2 R3 R4 R5 R9: table walk
    for (int v = 0; v < 7; v++) begin
      buf_ready = VEC[v][18:15];
      buf_prio  = VEC[v][14:3];
      hw_cmd    = 1'b1;
      #1;
      chk("R2", 64'(sel_valid), 64'(VEC[v][0]));
      chk((v == 3 || v == 4) ? "R3" : "R2", 64'(sel_idx), 64'(VEC[v][2:1]));
      @(negedge clk);
      hw_cmd = 1'b0;
      @(negedge clk);
      if (VEC[v][0]) expect_load(int'(VEC[v][2:1]), "R4");
      else
        for (int k = 0; k < 6; k++) begin
          chk("R9", 64'(frame_ready), 64'd0);
          @(negedge clk);
        end
    end

    // R6: selection changes mid-load
    buf_ready = 4'b0001; buf_prio = '0; hw_cmd = 1'b1;
    @(negedge clk); hw_cmd = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R6", 64'(ram_addr), 64'd1);
    buf_ready = 4'b0101; buf_prio = {3'd0, 3'd5, 3'd0, 3'd0};
    @(negedge clk);
    expect_load(2, "R6");

    // R7: software reload while holding
    sw_cmd = 1'b1;
    @(negedge clk); sw_cmd = 1'b0;
    expect_load(2, "R7");

    // R8: both strobes together, hardware wins
    sw_cmd = 1'b1; hw_cmd = 1'b1;
    @(negedge clk); sw_cmd = 1'b0; hw_cmd = 1'b0;
    chk("R8", 64'(frame_ready), 64'd0);
    @(negedge clk);
    expect_load(2, "R8");

    // R9: all buffers drop out during a load
    buf_ready = 4'b0100; hw_cmd = 1'b1;
    @(negedge clk); hw_cmd = 1'b0;
    @(negedge clk);
    @(negedge clk);
    buf_ready = 4'b0000;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      chk("R9", 64'(frame_ready), 64'd0);
    end
    buf_ready = 4'b1000;
    @(negedge clk);
    expect_load(3, "R9");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule